// File: doc/BRIEF.md
# Ready-Latency Packet Stream Transmitter

This block sits between an application packet source and a 64-bit transmit port on a link core. On that port the ready signal has a fixed latency. A beat may be presented with valid high only in a cycle whose ready, sampled a configured number of cycles earlier, was 1. Every beat presented with valid high is taken by the core. The upstream side hands over packet words through a plain valid/ready handshake. Each word carries a start-of-packet flag and an end-of-packet flag.

A one-word output stage holds the next beat to send. A short shift register records the recent history of the core's ready. A hold-off counter keeps the port silent for a set number of cycles after reset is released, even when ready is already high. Back-pressure rules: upstream must hold a word and its flags stable while `up_valid` is high and `up_ready` is low. A word is taken on every rising edge where both are high. `up_ready` depends only on registered state, never on the same cycle's `lk_ready`. The block adds no gap inside a packet. Once a word is held and the latency rule allows it, it goes out. A packet is therefore contiguous on the link as long as upstream supplies its words back to back.

Top module: `rlat_pkt_tx`

## Requirements
- R1: While reset is asserted and in the cycle it is released, `lk_valid` is 0 and `up_ready` is 1.
- R2: `lk_valid` is 1 in a cycle only if `lk_ready` was 1 exactly RDY_LAT cycles earlier (RDY_LAT is 1 or 2, default 2). A ready that drops therefore removes valid exactly RDY_LAT cycles later.
- R3: For the first HOLDOFF cycles after reset is released (default 2), `lk_valid` stays 0. This holds whatever `lk_ready` does during or after reset.
- R4: After the hold-off, when a beat is held and `lk_ready` was 1 RDY_LAT cycles earlier, `lk_valid` is 1. No bubble is inserted, and a paused packet resumes exactly RDY_LAT cycles after ready returns.
- R5: Beats leave in the order they were accepted, with data, start and end flags unchanged. A one-word packet shows start and end together on a single valid cycle.
- R6: While a held beat waits with `lk_valid` at 0, `lk_data`, `lk_sop` and `lk_eop` keep their values.
- R7: `up_ready` is 1 exactly when the output stage is empty or launches its beat in that cycle. No accepted word is ever overwritten or dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_valid | input | 1 | Upstream word offered |
| up_ready | output | 1 | Block takes the word at the next edge |
| up_data | input | 64 | Upstream packet word |
| up_sop | input | 1 | Word is first of its packet |
| up_eop | input | 1 | Word is last of its packet |
| lk_ready | input | 1 | Core ready, honoured RDY_LAT cycles later |
| lk_valid | output | 1 | Beat presented and taken by the core |
| lk_data | output | 64 | Beat data |
| lk_sop | output | 1 | Beat starts a packet |
| lk_eop | output | 1 | Beat ends a packet |

## Verification
The hardest case to reach is a beat that is already loaded and waiting, mid-packet, when the core's ready toggles with an arbitrary phase. The check must confirm that valid follows the ready history exactly RDY_LAT cycles later, neither early nor late. The stimulus sweeps all 64 six-cycle ready patterns, each repeated twice, while packets of one to four words stream in back to back. Every phase of pause and resume is hit at every position inside a packet. The hold-off is reached by keeping ready high through reset and offering a word at once. A bench with a hold-off longer than the latency separates the two rules.

// File: rtl/rlat_pkg.sv
package rlat_pkg;
  localparam int unsigned BEAT_W = 64;

  typedef struct packed {
    logic [BEAT_W-1:0] data;
    logic              sop;
    logic              eop;
  } beat_t;
endpackage

// File: rtl/rlat_ready_hist.sv
module rlat_ready_hist #(
  parameter int unsigned RDY_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_in,
  output logic allow
);
  generate
    if (RDY_LAT == 1) begin : g_one
      logic h_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= 1'b0;
        else        h_q <= rdy_in;
      end
      assign allow = h_q;
    end else begin : g_multi
      logic [RDY_LAT-1:0] h_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= {h_q[RDY_LAT-2:0], rdy_in};
      end
      assign allow = h_q[RDY_LAT-1];
    end
  endgenerate
endmodule

// File: rtl/rlat_holdoff.sv
module rlat_holdoff #(
  parameter int unsigned HOLDOFF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic go
);
  generate
    if (HOLDOFF == 0) begin : g_none
      assign go = 1'b1;
    end else begin : g_cnt
      localparam int unsigned CW = $clog2(HOLDOFF + 1);
      localparam logic [CW-1:0] LIMIT = CW'(HOLDOFF);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      end
      assign go = (cnt_q == LIMIT);
    end
  endgenerate
endmodule

// File: rtl/rlat_beat_stage.sv
module rlat_beat_stage
  import rlat_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  beat_t load_beat,
  input  logic  launch,
  output logic  full,
  output beat_t held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      held <= '0;
    end else begin
      if (load) begin
        full <= 1'b1;
        held <= load_beat;
      end else if (launch) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rlat_pkt_tx.sv
module rlat_pkt_tx
  import rlat_pkg::*;
#(
  parameter int unsigned RDY_LAT = 2,
  parameter int unsigned HOLDOFF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [BEAT_W-1:0] up_data,
  input  logic              up_sop,
  input  logic              up_eop,
  input  logic              lk_ready,
  output logic              lk_valid,
  output logic [BEAT_W-1:0] lk_data,
  output logic              lk_sop,
  output logic              lk_eop
);
  logic  allow, go, full, load;
  beat_t in_beat, held;

  rlat_ready_hist #(.RDY_LAT(RDY_LAT)) u_hist (
    .clk(clk), .rst_n(rst_n), .rdy_in(lk_ready), .allow(allow)
  );

  rlat_holdoff #(.HOLDOFF(HOLDOFF)) u_hold (
    .clk(clk), .rst_n(rst_n), .go(go)
  );

  // launch decision uses registered state only
  assign lk_valid = full && allow && go;
  assign up_ready = !full || lk_valid;
  assign load     = up_valid && up_ready;

  always_comb begin
    in_beat.data = up_data;
    in_beat.sop  = up_sop;
    in_beat.eop  = up_eop;
  end

  rlat_beat_stage u_stage (
    .clk(clk), .rst_n(rst_n), .load(load), .load_beat(in_beat),
    .launch(lk_valid), .full(full), .held(held)
  );

  assign lk_data = held.data;
  assign lk_sop  = held.sop;
  assign lk_eop  = held.eop;
endmodule

// File: rtl/rlat_pkt_tx_chk.sv
module rlat_pkt_tx_chk #(
  parameter int unsigned RDY_LAT = 2,
  parameter int unsigned HOLDOFF = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        up_ready,
  input logic        lk_ready,
  input logic        lk_valid,
  input logic [63:0] lk_data,
  input logic        lk_sop,
  input logic        lk_eop
);
  int unsigned since_q;
  logic        in_pkt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q  <= 0;
      in_pkt_q <= 1'b0;
    end else begin
      if (since_q < HOLDOFF) since_q <= since_q + 1;
      if (lk_valid) in_pkt_q <= !lk_eop;
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $past(lk_ready, RDY_LAT));

  assert_holdoff_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (since_q >= HOLDOFF));

  assert_no_bubble_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt_q && $past(lk_ready, RDY_LAT) && !lk_valid) |-> up_ready);

  assert_hold_paused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_valid && !up_ready) |=> ($stable(lk_data) && $stable(lk_sop) && $stable(lk_eop)));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> up_ready);
endmodule

bind rlat_pkt_tx rlat_pkt_tx_chk #(.RDY_LAT(RDY_LAT), .HOLDOFF(HOLDOFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_ready(up_ready), .lk_ready(lk_ready),
  .lk_valid(lk_valid), .lk_data(lk_data), .lk_sop(lk_sop), .lk_eop(lk_eop)
);

// File: tb/rlat_pkt_tx_tb.sv
module rlat_pkt_tx_tb;
  localparam int LAT  = 2;
  localparam int HOLD = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_valid = 1'b0, up_sop = 1'b0, up_eop = 1'b0;
  logic [63:0] up_data = '0;
  logic        lk_ready = 1'b1;
  logic        up_ready, lk_valid, lk_sop, lk_eop;
  logic [63:0] lk_data;

  int n_chk = 0, n_bad = 0;
  logic [65:0] q[$];

  always #4 clk = ~clk;

  rlat_pkt_tx #(.RDY_LAT(LAT), .HOLDOFF(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
    .up_data(up_data), .up_sop(up_sop), .up_eop(up_eop), .lk_ready(lk_ready),
    .lk_valid(lk_valid), .lk_data(lk_data), .lk_sop(lk_sop), .lk_eop(lk_eop)
  );

  task automatic chk(input bit ok, input string req, input logic [65:0] act, input logic [65:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    int  held = 0;
    bit  r1 = 0, r2 = 0;
    bit  pend = 0;
    int  pkt = 0, wrd = 0;
    bit  exp_v, exp_r, acc;
    logic [65:0] front;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(lk_valid == 1'b0, "R1 valid in reset", 66'(lk_valid), 66'd0);
    chk(up_ready == 1'b1, "R1 up_ready in reset", 66'(up_ready), 66'd1);
    rst_n = 1'b1;
    for (int i = 0; i < 8 + 64 * 12; i++) begin
      if (i > 0) @(negedge clk);
      exp_v = (held > 0) && (i >= HOLD) && r2;
      exp_r = (held == 0) || exp_v;
      if (i == 0) begin
        chk(lk_valid == 1'b0, "R1 valid at release", 66'(lk_valid), 66'd0);
        chk(up_ready == 1'b1, "R1 up_ready at release", 66'(up_ready), 66'd1);
      end
      if (i < HOLD)
        chk(lk_valid == 1'b0, "R3 hold-off", 66'(lk_valid), 66'd0);
      chk(lk_valid == exp_v, (lk_valid && !r2) ? "R2 latency" : "R4 valid when allowed",
          66'(lk_valid), 66'(exp_v));
      chk(up_ready == exp_r, "R7 up_ready", 66'(up_ready), 66'(exp_r));
      if (held > 0) begin
        front = q[0];
        if (lk_valid)
          chk({lk_data, lk_sop, lk_eop} == front, "R5 beat order/content",
              {lk_data, lk_sop, lk_eop}, front);
        else
          chk({lk_data, lk_sop, lk_eop} == front, "R6 paused beat held",
              {lk_data, lk_sop, lk_eop}, front);
      end
      // drive inputs for this interval
      if (i < 8) lk_ready = 1'b1;
      else begin
        int p = (i - 8) / 12;
        lk_ready = p[(i - 8) % 6];
      end
      if (!pend) begin
        if (wrd == 0 && (i % 7 == 3)) up_valid = 1'b0;
        else begin
          up_valid = 1'b1;
          up_sop   = (wrd == 0);
          up_eop   = (wrd == (pkt % 4));
          up_data  = {32'hA5A5_0000 | 32'(pkt), 32'(wrd)};
          pend     = 1'b1;
        end
      end
      acc = up_valid && up_ready;
      if (acc) begin
        q.push_back({up_data, up_sop, up_eop});
        pend = 1'b0;
        if (up_eop) begin pkt++; wrd = 0; end
        else wrd++;
      end
      if (lk_valid && held > 0) begin
        void'(q.pop_front());
      end
      held = held - (lk_valid ? 1 : 0) + (acc ? 1 : 0);
      r2 = r1;
      r1 = lk_ready;
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule